// File: doc/BRIEF.md
# Dual-Field Bit-Serial Montgomery Multiplier

This block forms the Montgomery product A·B·2^−m of two field elements, either modulo an odd prime p or, in binary extension field mode, modulo an irreducible polynomial over GF(2). A select input chooses the mode. The block consumes one bit of A per clock, starting at bit 0. Each step adds the selected multiple of B and the quotient multiple of the modulus to a running remainder R, and then halves R. After m such steps a single bounding cycle runs. In prime mode that cycle subtracts p once if R is still at least p. In binary mode R is already of degree below m and passes through unchanged.

One carry-save 3:2 stage serves both fields. In prime mode its sum and carry vectors meet in a carry-propagate adder. In binary mode the carry vector is forced to zero, so the stage reduces to a three-way XOR. The length m, the operands, the modulus and the mode are all captured when start is accepted. Any m from 1 up to the width parameter can therefore be used, and the inputs may change freely while an operation runs. Conversion into and out of the Montgomery domain is left to the surrounding logic.

Top module: `dfmm_top`

## Requirements
- R1: After a synchronous reset, done is 0 and result is 0.
- R2: With field select 0 (prime mode), for an odd modulus p < 2^m and operands A, B < p, result equals A·B·2^−m mod p and is below p.
- R3: With field select 1 (binary mode), for a modulus polynomial with bit m and bit 0 set and operands of degree below m, result equals A·B·x^−m reduced modulo the polynomial, with all coefficient arithmetic in GF(2), and has degree below m.
- R4: done rises exactly m+1 clock edges after the edge that samples start, so it is first seen high m+2 falling edges after start is driven.
- R5: done is high for exactly one cycle per operation.
- R6: result holds its value in every cycle except the one in which done is high.
- R7: A start pulse that arrives while an operation is in progress is ignored: it affects neither the result nor the timing of the operation in progress.
- R8: The length m is captured at start. Any m from 1 to WIDTH works, and changing the length input during an operation has no effect.
- R9: When either operand is zero, the result is zero in both modes.
- R10: The field select is captured at start. Changing it during an operation has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins an operation when the block is idle |
| field_bin | input | 1 | 0 = prime field, 1 = binary extension field |
| len | input | $clog2(WIDTH+1) | Field length m, 1 to WIDTH |
| op_a | input | WIDTH | Operand A, scanned from bit 0 |
| op_b | input | WIDTH | Operand B |
| modulus | input | WIDTH+1 | Prime p, or polynomial with bit m set |
| result | output | WIDTH | Montgomery product |
| done | output | 1 | One-cycle pulse when result is updated |

## Verification
The embedded assertions check the following on every cycle:
- each per-step sum is even and fits the remainder register;
- the step counter stays below the latched length;
- done lasts one cycle, and result changes only together with done;
- a finished prime result lies below p, and a finished binary result has degree below m;
- a start pulse during an operation leaves the latched length untouched.

Only the bench's scenarios can show the following:
- that the product is numerically correct in each field, which the bench confirms against a separate reference that reduces first and halves afterwards;
- that the latency is exact for lengths 1 and WIDTH;
- that changing the operands, length and mode during an operation leaves both the result and its timing unchanged.

// File: rtl/dfmm_pkg.sv
package dfmm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FINAL = 2'd2
    } dfmm_state_e;

    typedef enum logic {
        FLD_PRIME = 1'b0,
        FLD_BIN   = 1'b1
    } dfmm_field_e;

    // Quotient bit that makes R + s*B + q*P even.
    function automatic logic quot_bit(input logic s, input logic b0, input logic r0);
        return (s & b0) ^ r0;
    endfunction

endpackage

// File: rtl/dfmm_csa.sv
module dfmm_csa #(
    parameter int N = 18
) (
    input  logic [N-1:0] x,
    input  logic [N-1:0] y,
    input  logic [N-1:0] z,
    input  logic         no_carry,
    output logic [N-1:0] sum,
    output logic [N-1:0] carry
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign sum[i]   = x[i] ^ y[i] ^ z[i];
        assign carry[i] = no_carry ? 1'b0
                        : ((x[i] & y[i]) | (x[i] & z[i]) | (y[i] & z[i]));
    end
endmodule

// File: rtl/dfmm_cpa.sv
module dfmm_cpa #(
    parameter int N = 18
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic         cin,
    output logic [N-1:0] sum,
    output logic         cout
);
    logic [N:0] wide;
    assign wide = {1'b0, a} + {1'b0, b} + {{N{1'b0}}, cin};
    assign sum  = wide[N-1:0];
    assign cout = wide[N];
endmodule

// File: rtl/dfmm_ctrl.sv
module dfmm_ctrl
    import dfmm_pkg::*;
#(
    parameter int KW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [KW-1:0] len,
    output logic          load,
    output logic          step,
    output logic          fin,
    output logic [KW-1:0] m_len
);
    dfmm_state_e   state_q;
    logic [KW-1:0] k_q;
    logic [KW-1:0] m_q;
    logic          last;

    assign load  = (state_q == ST_IDLE) && start;
    assign step  = (state_q == ST_RUN);
    assign fin   = (state_q == ST_FINAL);
    assign last  = (k_q == m_q - KW'(1));
    assign m_len = m_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            k_q     <= '0;
            m_q     <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    m_q     <= len;
                    k_q     <= '0;
                    state_q <= (len == '0) ? ST_FINAL : ST_RUN;
                end
                ST_RUN: begin
                    k_q <= k_q + KW'(1);
                    if (last) state_q <= ST_FINAL;
                end
                ST_FINAL: state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // R4: the step counter never reaches the latched length while stepping
    a_r4_k_below_len: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN) |-> (k_q < m_q));

    // R7 / R8: start during an operation does not disturb the latched length
    a_r7_start_ignored: assert property (@(posedge clk) disable iff (rst)
        ((state_q != ST_IDLE) && start) |=> (m_q == $past(m_q)));

endmodule

// File: rtl/dfmm_top.sv
module dfmm_top
    import dfmm_pkg::*;
#(
    parameter int WIDTH = 16,
    localparam int KW   = $clog2(WIDTH + 1),
    localparam int RW   = WIDTH + 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             field_bin,
    input  logic [KW-1:0]    len,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [WIDTH:0]   modulus,
    output logic [WIDTH-1:0] result,
    output logic             done
);
    logic             load, step, fin;
    logic [KW-1:0]    m_len;

    logic [WIDTH-1:0] a_q, b_q, res_q;
    logic [WIDTH:0]   p_q;
    dfmm_field_e      fld_q;
    logic [RW-1:0]    r_q;
    logic             done_q;

    logic             s_bit, q_bit;
    logic [RW-1:0]    b_ext, p_ext, add_b, add_p;
    logic [RW-1:0]    csa_sum, csa_carry, step_full, r_next;
    logic             step_cout;
    logic [RW-1:0]    diff;
    logic             no_borrow;

    dfmm_ctrl #(.KW(KW)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .len   (len),
        .load  (load),
        .step  (step),
        .fin   (fin),
        .m_len (m_len)
    );

    assign s_bit = a_q[0];
    assign q_bit = quot_bit(s_bit, b_q[0], r_q[0]);
    assign b_ext = {2'b00, b_q};
    assign p_ext = {1'b0, p_q};
    assign add_b = s_bit ? b_ext : '0;
    assign add_p = q_bit ? p_ext : '0;

    // Shared 3:2 stage; carries suppressed in binary mode
    dfmm_csa #(.N(RW)) u_csa (
        .x        (r_q),
        .y        (add_b),
        .z        (add_p),
        .no_carry (fld_q == FLD_BIN),
        .sum      (csa_sum),
        .carry    (csa_carry)
    );

    // Carry resolve (carry is zero in binary mode, so sum passes through)
    dfmm_cpa #(.N(RW)) u_cpa_step (
        .a    (csa_sum),
        .b    ({csa_carry[RW-2:0], 1'b0}),
        .cin  (1'b0),
        .sum  (step_full),
        .cout (step_cout)
    );

    assign r_next = {1'b0, step_full[RW-1:1]};

    // Final bound: R - p via two's complement
    dfmm_cpa #(.N(RW)) u_cpa_bound (
        .a    (r_q),
        .b    (~p_ext),
        .cin  (1'b1),
        .sum  (diff),
        .cout (no_borrow)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q    <= '0;
            b_q    <= '0;
            p_q    <= '0;
            fld_q  <= FLD_PRIME;
            r_q    <= '0;
            res_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load) begin
                a_q   <= op_a;
                b_q   <= op_b;
                p_q   <= modulus;
                fld_q <= field_bin ? FLD_BIN : FLD_PRIME;
                r_q   <= '0;
            end
            if (step) begin
                r_q <= r_next;
                a_q <= a_q >> 1;
            end
            if (fin) begin
                if ((fld_q == FLD_PRIME) && no_borrow)
                    res_q <= diff[WIDTH-1:0];
                else
                    res_q <= r_q[WIDTH-1:0];
                done_q <= 1'b1;
            end
        end
    end

    assign result = res_q;
    assign done   = done_q;

    // R2: every per-step sum is even and fits the remainder register
    a_r2_step_even: assert property (@(posedge clk) disable iff (rst)
        step |-> (step_full[0] == 1'b0));
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
        step |-> (!step_cout && !csa_carry[RW-1]));
    // R2: a subtracted result fits in WIDTH bits
    a_r2_bound_fits: assert property (@(posedge clk) disable iff (rst)
        (fin && (fld_q == FLD_PRIME) && no_borrow) |-> (diff[RW-1:WIDTH] == '0));
    // R2: prime result below p
    a_r2_prime_range: assert property (@(posedge clk) disable iff (rst)
        (done && (fld_q == FLD_PRIME)) |-> ({1'b0, result} < p_q));
    // R3: binary result degree below m
    a_r3_bin_degree: assert property (@(posedge clk) disable iff (rst)
        (done && (fld_q == FLD_BIN)) |-> ((result >> m_len) == '0));
    // R5: done is a single-cycle pulse
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R6: result only moves together with done
    a_r6_result_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable(result) |-> done);

endmodule

// File: tb/dfmm_top_bench.sv
module dfmm_top_bench;
    localparam int W  = 16;
    localparam int KW = $clog2(W + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          field_bin = 1'b0;
    logic [KW-1:0] len = '0;
    logic [W-1:0]  op_a = '0, op_b = '0;
    logic [W:0]    modulus = '0;
    logic [W-1:0]  result;
    logic          done;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    dfmm_top #(.WIDTH(W)) u_dfmm_top (
        .clk(clk), .rst(rst), .start(start), .field_bin(field_bin), .len(len),
        .op_a(op_a), .op_b(op_b), .modulus(modulus), .result(result), .done(done)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles, expected below 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input longint unsigned act,
                         input longint unsigned exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic longint unsigned ref_prime(longint unsigned a, longint unsigned b,
                                                  longint unsigned p, int m);
        longint unsigned x = (a * b) % p;
        for (int i = 0; i < m; i++) begin
            if (x[0]) x = x + p;
            x = x >> 1;
        end
        return x;
    endfunction

    function automatic longint unsigned ref_bin(longint unsigned a, longint unsigned b,
                                                longint unsigned p, int m);
        longint unsigned x = 0;
        for (int i = 0; i < W; i++)
            if (a[i]) x = x ^ (b << i);
        for (int i = 2 * W; i >= m; i--)
            if (x[i]) x = x ^ (p << (i - m));
        for (int i = 0; i < m; i++) begin
            if (x[0]) x = x ^ p;
            x = x >> 1;
        end
        return x;
    endfunction

    // Runs one operation; optionally disturbs inputs mid-run (R7/R8/R10).
    task automatic run_op(input string req, input bit bin, input int m,
                          input longint unsigned a, input longint unsigned b,
                          input longint unsigned p, input bit disturb);
        longint unsigned exp;
        int n = 0;
        exp = bin ? ref_bin(a, b, p, m) : ref_prime(a, b, p, m);
        @(negedge clk);
        field_bin = bin; len = KW'(m); op_a = W'(a); op_b = W'(b);
        modulus = (W + 1)'(p); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 200) begin
            if (disturb && n == 2) begin
                start = 1'b1; field_bin = ~bin; len = KW'(W);
                op_a = ~op_a; op_b = ~op_b; modulus = ~modulus;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        check({req, " result"}, result, exp);
        check("R4 latency", n, m + 2);
        @(negedge clk);
        check("R5 done low after pulse", done, 0);
        check("R6 result held", result, exp);
    endtask

    initial begin
        longint unsigned p, a, b;
        int m;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 done after reset", done, 0);
        check("R1 result after reset", result, 0);
        rst = 1'b0;

        // Directed corners
        run_op("R2 prime small", 0, 4, 3, 5, 11, 0);
        run_op("R8 prime m=1", 0, 1, 0, 0, 1, 0);
        run_op("R8 prime m=W", 0, W, 16'hfff0, 16'h1234, 17'h0fff1, 0);
        run_op("R9 prime zero A", 0, 12, 0, 77, 4093, 0);
        run_op("R9 binary zero B", 1, 8, 8'h5a, 0, 17'h11b, 0);
        run_op("R3 binary m=8", 1, 8, 8'h57, 8'h83, 17'h11b, 0);
        run_op("R8 binary m=1", 1, 1, 1, 1, 3, 0);
        run_op("R8 binary m=W", 1, W, 16'hbeef, 16'hcafe, 17'h1002b, 0);
        run_op("R7 R10 prime disturbed", 0, 10, 500, 777, 1009, 1);
        run_op("R7 R10 binary disturbed", 1, 9, 9'h1a5, 9'h0f3, 17'h211, 1);

        // Constrained random
        for (int t = 0; t < 60; t++) begin
            m = 1 + int'($urandom % W);
            if (t % 2 == 0) begin
                p = (longint'($urandom) % (64'd1 << m)) | 64'd1;
                a = longint'($urandom) % p;
                b = longint'($urandom) % p;
                run_op("R2 prime random", 0, m, a, b, p, (t % 7) == 0);
            end else begin
                p = (64'd1 << m) | (longint'($urandom) % (64'd1 << m)) | 64'd1;
                a = longint'($urandom) % (64'd1 << m);
                b = longint'($urandom) % (64'd1 << m);
                run_op("R3 binary random", 1, m, a, b, p, (t % 5) == 0);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule